// File: doc/BRIEF.md
# Paged Register Serial Slave

This block is a serial peripheral slave that lets a host read and write a small banked register file over a four-wire SPI link. The host holds the active-high select high for one frame. Every field in the frame goes most significant bit first. The frame opens with a direction bit, then a 2-bit page code, then an 8-bit register address and a burst flag. Four idle bits follow, and after them come whole data bytes. The idle bits give the slave time to fetch the first read byte.

The block samples SCLK, select and serial input through two-stage synchronizers running on the system clock. It captures input on SCLK rising edges and updates its serial output on falling edges. A live configuration input, the page-select bit, sets which internal bank page code 1 reaches. Page code 0 always reaches bank 1. Page codes 2 and 3 would lead to the protected banks and reach nothing. A burst frame steps the register address after every complete byte. A single-access frame acts on its first byte only.

Top module: `spi_paged_slave`

## Requirements
- R1: Header bits arrive in this order: direction, page code (2 bits), register address (8 bits), burst flag, then 4 don't-care bits. Data bytes follow. Every field is MSB first, and a byte written to an address reads back unchanged.
- R2: A direction bit of 1 writes and a direction bit of 0 reads. A read frame never changes the register file, whatever data the host shifts in.
- R3: With the burst flag at 0, only the first data byte is acted on. Later bytes are not written, and the serial output stays disabled while they are sent.
- R4: With the burst flag at 1, each complete byte goes to the next address. The address wraps from 0xFF to 0x00.
- R5: A byte cut short by select falling before its eighth bit is discarded and writes nothing.
- R6: During a write frame `sdo_en_o` stays 0 and `sdo_o` stays 0 for the whole frame.
- R7: During a read frame the output is disabled for the 16 header bits, including the 4 don't-care bits. From the first data bit on, `sdo_o` carries valid read data, MSB first, changed on falling SCLK edges.
- R8: Page code 0 selects bank 1. Page code 1 selects bank 2 when `page_sel_i` = 0 and bank 3 when `page_sel_i` = 1.
- R9: Page codes 2 and 3 reach no storage. Writes to them have no effect and reads from them return 0x00.
- R10: After reset every register holds 0x00 and the output is disabled.
- R11: While select is low, `sdo_en_o` and `sdo_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from host, idle low |
| sce_i | input | 1 | Frame enable from host, active high |
| sdi_i | input | 1 | Serial data from host |
| page_sel_i | input | 1 | Bank remap for page code 1 |
| sdo_o | output | 1 | Serial read data, 0 when disabled |
| sdo_en_o | output | 1 | Output drive enable for sdo_o |

## Verification
The bench builds the block with its defaults: an 8-bit address, a 2-bit page code and two synchronizer stages. The full 256-entry address space therefore fits in the bench's own model of the three banks, so address wrap from 0xFF to 0x00 during a burst is reachable in a short run. The 2-bit page code lets stimulus reach both unmapped codes as well as both settings of the remap bit. With two synchronizer stages, an SCLK half period of six system clocks leaves settled output well ahead of each host sampling point.

// File: rtl/spi_paged_pkg.sv
package spi_paged_pkg;
  localparam int PAD_BITS  = 4;
  localparam int NUM_BANKS = 3;
  typedef enum logic {PH_HDR, PH_DATA} phase_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sce_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic sce_o,
  output logic sdi_o
);
  logic [STAGES:0]   sclk_sr;
  logic [STAGES-1:0] sce_sr, sdi_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_sr <= '0;
      sce_sr  <= '0;
      sdi_sr  <= '0;
    end else begin
      sclk_sr <= {sclk_sr[STAGES-1:0], sclk_i};
      sce_sr  <= {sce_sr[STAGES-2:0], sce_i};
      sdi_sr  <= {sdi_sr[STAGES-2:0], sdi_i};
    end
  end

  assign rise_o = sclk_sr[STAGES-1] & ~sclk_sr[STAGES];
  assign fall_o = ~sclk_sr[STAGES-1] & sclk_sr[STAGES];
  assign sce_o  = sce_sr[STAGES-1];
  assign sdi_o  = sdi_sr[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_paged_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sce_i,
  input  logic              sdi_i,
  input  logic [7:0]        rd_data_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              sdo_o,
  output logic              sdo_en_o
);
  localparam int HDR_W = 1 + PAGE_W + ADDR_W + 1 + PAD_BITS;
  localparam int CNT_W = $clog2(HDR_W + 1);

  phase_e            phase;
  logic [CNT_W-1:0]  hdr_cnt;
  logic [HDR_W-2:0]  hdr_sr;
  logic [HDR_W-1:0]  hdr_full;
  logic [2:0]        bit_idx;
  logic [6:0]        rx_sr;
  logic [7:0]        tx_byte;
  logic              wr_q, burst_q, done_q, sdo_bit, sdo_en;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] addr_q;
  logic              byte_done;

  assign hdr_full  = {hdr_sr, sdi_i};
  assign byte_done = rise_i && (phase == PH_DATA) && (bit_idx == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase     <= PH_HDR;
      hdr_cnt   <= '0;
      hdr_sr    <= '0;
      bit_idx   <= '0;
      rx_sr     <= '0;
      tx_byte   <= '0;
      wr_q      <= 1'b0;
      burst_q   <= 1'b0;
      done_q    <= 1'b0;
      page_q    <= '0;
      addr_q    <= '0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      sdo_bit   <= 1'b0;
      sdo_en    <= 1'b0;
    end else if (!sce_i) begin
      phase    <= PH_HDR;
      hdr_cnt  <= '0;
      bit_idx  <= '0;
      done_q   <= 1'b0;
      wr_stb_o <= 1'b0;
      sdo_bit  <= 1'b0;
      sdo_en   <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      if (rise_i) begin
        if (phase == PH_HDR) begin
          hdr_sr  <= hdr_full[HDR_W-2:0];
          hdr_cnt <= hdr_cnt + 1'b1;
          if (hdr_cnt == CNT_W'(HDR_W - 1)) begin
            wr_q    <= hdr_full[HDR_W-1];
            page_q  <= hdr_full[HDR_W-2 -: PAGE_W];
            addr_q  <= hdr_full[HDR_W-2-PAGE_W -: ADDR_W];
            burst_q <= hdr_full[PAD_BITS];
            phase   <= PH_DATA;
          end
        end else begin
          rx_sr   <= {rx_sr[5:0], sdi_i};
          bit_idx <= bit_idx + 1'b1;
          if (bit_idx == 3'd7) begin
            if (wr_q && !done_q) begin
              wr_stb_o  <= 1'b1;
              wr_addr_o <= addr_q;
              wr_data_o <= {rx_sr, sdi_i};
            end
            addr_q <= addr_q + 1'b1;
            if (!burst_q) done_q <= 1'b1;
          end
        end
      end
      // output moves on falling edges; bit_idx already names the next bit
      if (fall_i && phase == PH_DATA) begin
        sdo_en <= !wr_q && !done_q;
        if (bit_idx == 3'd0) begin
          tx_byte <= rd_data_i;
          sdo_bit <= rd_data_i[7];
        end else begin
          sdo_bit <= tx_byte[3'd7 - bit_idx];
        end
      end
    end
  end

  assign page_o    = page_q;
  assign rd_addr_o = addr_q;
  assign sdo_en_o  = sdo_en;
  assign sdo_o     = sdo_en & sdo_bit;

  p_no_sdo_on_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_en |-> !wr_q);
  p_quiet_without_sce_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sce_i |=> !sdo_en_o);
  p_header_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_HDR) |-> !sdo_en_o);
  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && sce_i) |=> (addr_q == $past(addr_q) + 1'b1));
  p_single_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !burst_q) |=> !wr_stb_o);
  p_strobe_is_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> wr_q);
endmodule

// File: rtl/spi_reg_banks.sv
module spi_reg_banks
  import spi_paged_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              page_sel_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int BK_W  = $clog2(NUM_BANKS);

  logic                          hit;
  logic [BK_W-1:0]               bank;
  logic [NUM_BANKS-1:0][7:0]     bank_rd;

  // code 0 -> bank 1, code 1 -> bank 2 or 3, higher codes are protected
  always_comb begin
    hit  = 1'b1;
    bank = '0;
    if (page_i == PAGE_W'(0))      bank = BK_W'(0);
    else if (page_i == PAGE_W'(1)) bank = page_sel_i ? BK_W'(2) : BK_W'(1);
    else                           hit  = 1'b0;
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_stb_i && hit && bank == BK_W'(g)) begin
        mem[wr_addr_i] <= wr_data_i;
      end
    end
    assign bank_rd[g] = mem[rd_addr_i];
  end

  assign rd_data_o = hit ? bank_rd[bank] : 8'h00;

  p_bank_in_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |-> (bank < BK_W'(NUM_BANKS)));
endmodule

// File: rtl/spi_paged_slave.sv
module spi_paged_slave #(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sce_i,
  input  logic sdi_i,
  input  logic page_sel_i,
  output logic sdo_o,
  output logic sdo_en_o
);
  logic              rise, fall, sce_s, sdi_s, wr_stb;
  logic [PAGE_W-1:0] page;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [7:0]        rd_data, wr_data;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sce_i(sce_i), .sdi_i(sdi_i),
    .rise_o(rise), .fall_o(fall), .sce_o(sce_s), .sdi_o(sdi_s)
  );

  spi_frame_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise), .fall_i(fall), .sce_i(sce_s),
    .sdi_i(sdi_s), .rd_data_i(rd_data), .page_o(page), .rd_addr_o(rd_addr),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .sdo_o(sdo_o), .sdo_en_o(sdo_en_o)
  );

  spi_reg_banks #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_banks (
    .clk_i(clk_i), .rst_ni(rst_ni), .page_sel_i(page_sel_i), .page_i(page),
    .rd_addr_i(rd_addr), .wr_stb_i(wr_stb), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_data_o(rd_data)
  );
endmodule

// File: tb/spi_paged_slave_test.sv
`timescale 1ns/1ps
module spi_paged_slave_test;
  localparam int H = 6;

  logic clk = 0, rst_ni = 0, sclk = 0, sce = 0, sdi = 0, page_sel = 0;
  logic sdo, sdo_en;
  int n_chk = 0, n_bad = 0;
  logic [7:0] model [0:2][0:255];
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];
  bit         enb  [0:7];
  bit         hdr_en_seen, any_en_seen;

  always #5 clk = ~clk;

  spi_paged_slave uut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sce_i(sce), .sdi_i(sdi),
    .page_sel_i(page_sel), .sdo_o(sdo), .sdo_en_o(sdo_en)
  );

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int bank_of(input bit [1:0] pg, input bit sel);
    if (pg == 2'd0) return 0;
    if (pg == 2'd1) return sel ? 2 : 1;
    return -1;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // one bit: set data, wait, sample output, rise, wait, fall
  task automatic shift_bit(input bit v, output bit so, output bit en);
    sdi = v;
    wait_clk(H);
    so = sdo; en = sdo_en;
    sclk = 1;
    wait_clk(H);
    sclk = 0;
  endtask

  task automatic frame(input bit rw, input bit [1:0] pg, input bit [7:0] ad, input bit bu,
                       input int nb, input int extra, input bit sel);
    bit [15:0] hdr;
    bit so, en;
    page_sel = sel;
    hdr = {rw, pg, ad, bu, 4'b1010};
    hdr_en_seen = 0; any_en_seen = 0;
    sce = 1;
    wait_clk(4);
    for (int i = 15; i >= 0; i--) begin
      shift_bit(hdr[i], so, en);
      if (en) hdr_en_seen = 1;
    end
    for (int b = 0; b < nb; b++) begin
      enb[b] = 1;
      for (int k = 7; k >= 0; k--) begin
        shift_bit(wbuf[b][k], so, en);
        rbuf[b][k] = so;
        if (!en) enb[b] = 0;
        if (en) any_en_seen = 1;
      end
    end
    for (int k = 0; k < extra; k++) begin
      shift_bit(1'b1, so, en);
      if (en) any_en_seen = 1;
    end
    wait_clk(H);
    sce = 0;
    sdi = 0;
    wait_clk(6);
    chk(sdo_en == 0 && sdo == 0, "R11", {sdo_en, sdo}, 0);
    wait_clk(4);
  endtask

  task automatic do_write(input bit [1:0] pg, input bit [7:0] ad, input bit bu, input int nb,
                          input int extra, input bit sel);
    int bk;
    frame(1'b1, pg, ad, bu, nb, extra, sel);
    chk(!any_en_seen, "R6", any_en_seen, 0);
    bk = bank_of(pg, sel);
    if (bk >= 0)
      for (int b = 0; b < nb; b++)
        if (b == 0 || bu) model[bk][8'(ad + b)] = wbuf[b];
  endtask

  task automatic do_read(input bit [1:0] pg, input bit [7:0] ad, input bit bu, input int nb,
                         input bit sel, input string req);
    int bk;
    logic [7:0] exp;
    frame(1'b0, pg, ad, bu, nb, 0, sel);
    chk(!hdr_en_seen, "R7", hdr_en_seen, 0);
    bk = bank_of(pg, sel);
    for (int b = 0; b < nb; b++) begin
      if (b == 0 || bu) begin
        exp = (bk >= 0) ? model[bk][8'(ad + b)] : 8'h00;
        chk(enb[b] && rbuf[b] == exp, req, {enb[b], rbuf[b]}, {1'b1, exp});
      end else begin
        chk(!enb[b], "R3", enb[b], 0);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int b = 0; b < 3; b++) for (int a = 0; a < 256; a++) model[b][a] = 8'h00;
    wait_clk(5);
    chk(sdo_en == 0 && sdo == 0, "R10", {sdo_en, sdo}, 0);
    rst_ni = 1;
    wait_clk(5);

    // R10: reset contents
    for (int b = 0; b < 8; b++) wbuf[b] = 8'h00;
    do_read(2'd0, 8'h00, 1'b1, 2, 1'b0, "R10");
    do_read(2'd1, 8'h80, 1'b0, 1, 1'b1, "R10");

    // R1: single write / read back, MSB-first pattern
    wbuf[0] = 8'hC3;
    do_write(2'd0, 8'h5A, 1'b0, 1, 0, 1'b0);
    do_read(2'd0, 8'h5A, 1'b0, 1, 1'b0, "R1");

    // R8: remap of page code 1
    wbuf[0] = 8'h11; do_write(2'd1, 8'h0A, 1'b0, 1, 0, 1'b0);
    wbuf[0] = 8'h22; do_write(2'd1, 8'h0A, 1'b0, 1, 0, 1'b1);
    do_read(2'd1, 8'h0A, 1'b0, 1, 1'b0, "R8");
    do_read(2'd1, 8'h0A, 1'b0, 1, 1'b1, "R8");
    do_read(2'd0, 8'h0A, 1'b0, 1, 1'b1, "R8");

    // R9: protected codes
    wbuf[0] = 8'hFF; do_write(2'd2, 8'h03, 1'b0, 1, 0, 1'b0);
    wbuf[0] = 8'hEE; do_write(2'd3, 8'h03, 1'b0, 1, 0, 1'b1);
    do_read(2'd2, 8'h03, 1'b0, 1, 1'b0, "R9");
    do_read(2'd3, 8'h03, 1'b0, 1, 1'b1, "R9");
    do_read(2'd0, 8'h03, 1'b0, 1, 1'b0, "R9");

    // R4: burst wrapping past 0xFF
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    do_write(2'd0, 8'hFE, 1'b1, 4, 0, 1'b0);
    do_read(2'd0, 8'hFE, 1'b1, 4, 1'b0, "R4");

    // R3: single access ignores trailing bytes
    wbuf[0] = 8'h3C; wbuf[1] = 8'h99;
    do_write(2'd1, 8'h40, 1'b0, 2, 0, 1'b1);
    do_read(2'd1, 8'h40, 1'b1, 2, 1'b1, "R3");
    do_read(2'd1, 8'h40, 1'b0, 2, 1'b1, "R3");

    // R5: partial bytes discarded
    wbuf[0] = 8'h77;
    do_write(2'd0, 8'h20, 1'b0, 0, 5, 1'b0);
    do_write(2'd0, 8'h30, 1'b1, 1, 7, 1'b0);
    do_read(2'd0, 8'h20, 1'b1, 1, 1'b0, "R5");
    do_read(2'd0, 8'h30, 1'b1, 2, 1'b0, "R5");

    // R2: read frame with active input data leaves contents alone
    wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
    do_read(2'd0, 8'hFE, 1'b1, 2, 1'b0, "R2");
    do_read(2'd0, 8'hFE, 1'b1, 2, 1'b0, "R2");

    // random mix
    for (int t = 0; t < 40; t++) begin
      bit rw, bu, sel;
      bit [1:0] pg;
      bit [7:0] ad;
      int nb;
      rw = 1'($urandom); bu = 1'($urandom); sel = 1'($urandom);
      pg = 2'($urandom_range(0, 3)); ad = 8'($urandom);
      nb = $urandom_range(1, 4);
      for (int b = 0; b < 8; b++) wbuf[b] = 8'($urandom);
      if (rw) do_write(pg, ad, bu, nb, 0, sel);
      else    do_read(pg, ad, bu, nb, sel, "R1");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule